// File: doc/BRIEF.md
# Ping-Pong Frame Buffer VGA Scan-Out

This block shows a small host-supplied picture on a VGA monitor through an external triple 8-bit video DAC. It holds two frame memories, each one source frame deep (64 by 48 pixels by default, one 24-bit colour word per pixel, 3072 words). One memory is the front buffer, which the scan-out logic reads. The other is the back buffer, which the host fills in a single burst of writes. Once the burst is done, the host writes a frame-done strobe.

The raster generator produces a 640x480 display at 60 Hz from a 25 MHz pixel clock by default. It drives active-low horizontal and vertical sync. Each stored pixel is repeated over a SCALE by SCALE square of screen pixels. The colour outputs are held at zero outside the visible area.

When vertical blanking begins and the back buffer has been marked complete, the two memories trade roles and an interrupt is raised asking for the next frame. The host clears the interrupt with an acknowledge pulse. If no complete frame is waiting, the current picture is shown again. The host port is synchronous to the pixel clock.

Top module: `vga_pingpong_display`

## Requirements
- R1: While reset is asserted, both sync outputs are high, all colour outputs are zero and the interrupt is low.
- R2: The horizontal sync output is low for exactly H_SYNC clocks of every H_ACTIVE+H_FRONT+H_SYNC+H_BACK clock line, starting H_ACTIVE+H_FRONT clocks after the line's first visible pixel.
- R3: The vertical sync output is low for exactly V_SYNC whole lines per frame, starting V_ACTIVE+V_FRONT lines after the first visible line.
- R4: Red, green and blue are all zero whenever the raster position is outside the visible H_ACTIVE by V_ACTIVE area.
- R5: Screen pixel (x, y) in the visible area shows the stored word at address (y/SCALE)*SRC_W + (x/SCALE), with bits [23:16] on red, [15:8] on green and [7:0] on blue.
- R6: Host writes land only in the back buffer; the frame on screen does not change while the back buffer is rewritten.
- R7: The buffers swap only at the first clock of vertical blanking, and only when a frame-done strobe has arrived since the previous swap. Without one, the same frame is shown again and no interrupt is raised.
- R8: The interrupt goes high in the clock after a swap and stays high until an acknowledge pulse. It is low in the clock after the acknowledge.
- R9: Host writes are ignored from the frame-done strobe until the following swap.
- R10: After a swap the former front buffer becomes the back buffer, so consecutive frames alternate between the two memories.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, also clocks the host port |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe into the back buffer |
| host_addr | input | clog2(SRC_W*SRC_H) | Pixel address, row-major |
| host_data | input | 3*COLOR_W | Pixel colour {red, green, blue} |
| host_frame_done | input | 1 | One-clock strobe: back buffer holds a complete frame |
| irq_ack | input | 1 | One-clock strobe clearing the interrupt |
| irq | output | 1 | Request for the next frame, set on swap |
| vga_hsync_n | output | 1 | Horizontal sync, active low |
| vga_vsync_n | output | 1 | Vertical sync, active low |
| vga_red | output | COLOR_W | Red channel to the DAC |
| vga_green | output | COLOR_W | Green channel to the DAC |
| vga_blue | output | COLOR_W | Blue channel to the DAC |

## Verification
Each frame image is a per-address pattern whose three colour bytes are each derived differently from the address and a frame seed. A wrong row stride, a missing replication, swapped channels or a stale buffer therefore shows up as a mismatch on a known screen pixel. Every scanned frame is compared over the full raster, blanking included, so the sync windows and the black border are checked in the same pass. One scenario writes a frame without the done strobe, which separates "shown again" from "swapped". Another overwrites a frame after its done strobe, which separates ignored writes from accepted ones. Three successive frames are shown so that both memories serve as front buffer.

// File: rtl/vpd_pkg.sv
package vpd_pkg;
  // Raster control bits produced for one pixel position.
  typedef struct packed {
    logic hs_n;
    logic vs_n;
    logic act;
  } scan_ctl_t;

  localparam int NUM_BANKS = 2;
endpackage

// File: rtl/vpd_timing.sv
module vpd_timing #(
  parameter int HA = 640,
  parameter int HF = 16,
  parameter int HS = 96,
  parameter int HB = 48,
  parameter int VA = 480,
  parameter int VF = 10,
  parameter int VS = 2,
  parameter int VB = 33,
  localparam int HT = HA + HF + HS + HB,
  localparam int VT = VA + VF + VS + VB,
  localparam int HW = $clog2(HT),
  localparam int VW = $clog2(VT)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [HW-1:0]     h_cnt,
  output logic [VW-1:0]     v_cnt,
  output logic              h_act,
  output logic              v_act,
  output logic              line_end,
  output logic              frame_end,
  output logic              vblank_start,
  output vpd_pkg::scan_ctl_t ctl
);
  logic [HW-1:0] h_nxt;
  logic [VW-1:0] v_nxt;

  always_comb begin
    line_end  = (h_cnt == HW'(HT - 1));
    frame_end = line_end && (v_cnt == VW'(VT - 1));
    h_nxt     = line_end ? '0 : h_cnt + HW'(1);
    v_nxt     = v_cnt;
    if (line_end) v_nxt = frame_end ? '0 : v_cnt + VW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_cnt <= '0;
      v_cnt <= '0;
    end else begin
      h_cnt <= h_nxt;
      v_cnt <= v_nxt;
    end
  end

  always_comb begin
    h_act        = (h_cnt < HW'(HA));
    v_act        = (v_cnt < VW'(VA));
    vblank_start = (v_cnt == VW'(VA)) && (h_cnt == '0);
    ctl.act      = h_act && v_act;
    ctl.hs_n     = !((h_cnt >= HW'(HA + HF)) && (h_cnt < HW'(HA + HF + HS)));
    ctl.vs_n     = !((v_cnt >= VW'(VA + VF)) && (v_cnt < VW'(VA + VF + VS)));
  end
endmodule

// File: rtl/vpd_scaler.sv
module vpd_scaler #(
  parameter int SRC_W = 64,
  parameter int SRC_H = 48,
  parameter int SCALE = 10,
  localparam int AW   = $clog2(SRC_W * SRC_H),
  localparam int SUBW = $clog2(SCALE + 1),
  localparam int XW   = $clog2(SRC_W + 1),
  localparam int YW   = $clog2(SRC_H + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_act,
  input  logic          v_act,
  input  logic          line_end,
  input  logic          frame_end,
  output logic [AW-1:0] rd_addr
);
  logic [SUBW-1:0] x_sub, x_sub_nxt, y_sub, y_sub_nxt;
  logic [XW-1:0]   x_blk, x_blk_nxt;
  logic [YW-1:0]   y_blk, y_blk_nxt;

  always_comb begin
    x_sub_nxt = x_sub;
    x_blk_nxt = x_blk;
    if (line_end) begin
      x_sub_nxt = '0;
      x_blk_nxt = '0;
    end else if (h_act) begin
      if (x_sub == SUBW'(SCALE - 1)) begin
        x_sub_nxt = '0;
        x_blk_nxt = x_blk + XW'(1);
      end else begin
        x_sub_nxt = x_sub + SUBW'(1);
      end
    end

    y_sub_nxt = y_sub;
    y_blk_nxt = y_blk;
    if (frame_end) begin
      y_sub_nxt = '0;
      y_blk_nxt = '0;
    end else if (line_end && v_act) begin
      if (y_sub == SUBW'(SCALE - 1)) begin
        y_sub_nxt = '0;
        y_blk_nxt = y_blk + YW'(1);
      end else begin
        y_sub_nxt = y_sub + SUBW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_sub <= '0;
      x_blk <= '0;
      y_sub <= '0;
      y_blk <= '0;
    end else begin
      x_sub <= x_sub_nxt;
      x_blk <= x_blk_nxt;
      y_sub <= y_sub_nxt;
      y_blk <= y_blk_nxt;
    end
  end

  assign rd_addr = AW'(y_blk * SRC_W) + AW'(x_blk);
endmodule

// File: rtl/vpd_frame_bank.sv
module vpd_frame_bank #(
  parameter int DEPTH = 3072,
  parameter int DW    = 24,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && (waddr < AW'(DEPTH))) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/vpd_swap_ctrl.sv
module vpd_swap_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic vblank_start,
  input  logic frame_done,
  input  logic irq_ack,
  output logic front_sel,
  output logic back_full,
  output logic swap,
  output logic irq
);
  logic front_nxt, full_nxt, irq_nxt;

  always_comb begin
    swap      = vblank_start && back_full;
    front_nxt = swap ? !front_sel : front_sel;
    full_nxt  = swap ? 1'b0 : (back_full || frame_done);
    irq_nxt   = swap ? 1'b1 : (irq && !irq_ack);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      front_sel <= 1'b0;
      back_full <= 1'b0;
      irq       <= 1'b0;
    end else begin
      front_sel <= front_nxt;
      back_full <= full_nxt;
      irq       <= irq_nxt;
    end
  end
endmodule

// File: rtl/vga_pingpong_display.sv
module vga_pingpong_display #(
  parameter int COLOR_W  = 8,
  parameter int SRC_W    = 64,
  parameter int SRC_H    = 48,
  parameter int SCALE    = 10,
  parameter int H_ACTIVE = 640,
  parameter int H_FRONT  = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BACK   = 48,
  parameter int V_ACTIVE = 480,
  parameter int V_FRONT  = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BACK   = 33
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                host_we,
  input  logic [$clog2(SRC_W*SRC_H)-1:0]      host_addr,
  input  logic [3*COLOR_W-1:0]                host_data,
  input  logic                                host_frame_done,
  input  logic                                irq_ack,
  output logic                                irq,
  output logic                                vga_hsync_n,
  output logic                                vga_vsync_n,
  output logic [COLOR_W-1:0]                  vga_red,
  output logic [COLOR_W-1:0]                  vga_green,
  output logic [COLOR_W-1:0]                  vga_blue
);
  import vpd_pkg::*;

  localparam int DEPTH = SRC_W * SRC_H;
  localparam int AW    = $clog2(DEPTH);
  localparam int DW    = 3 * COLOR_W;
  localparam int HT    = H_ACTIVE + H_FRONT + H_SYNC + H_BACK;
  localparam int VT    = V_ACTIVE + V_FRONT + V_SYNC + V_BACK;
  localparam int HW    = $clog2(HT);
  localparam int VW    = $clog2(VT);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_pipe;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  logic [HW-1:0] h_cnt;
  logic [VW-1:0] v_cnt;
  logic          h_act, v_act, line_end, frame_end, vblank_start;
  scan_ctl_t     ctl, ctl_q;

  vpd_timing #(
    .HA(H_ACTIVE), .HF(H_FRONT), .HS(H_SYNC), .HB(H_BACK),
    .VA(V_ACTIVE), .VF(V_FRONT), .VS(V_SYNC), .VB(V_BACK)
  ) timing_i (
    .clk(clk), .rst_n(rst_n_s), .h_cnt(h_cnt), .v_cnt(v_cnt),
    .h_act(h_act), .v_act(v_act), .line_end(line_end),
    .frame_end(frame_end), .vblank_start(vblank_start), .ctl(ctl)
  );

  logic [AW-1:0] rd_addr;
  vpd_scaler #(.SRC_W(SRC_W), .SRC_H(SRC_H), .SCALE(SCALE)) scaler_i (
    .clk(clk), .rst_n(rst_n_s), .h_act(h_act), .v_act(v_act),
    .line_end(line_end), .frame_end(frame_end), .rd_addr(rd_addr)
  );

  logic front_sel, back_full, swap;
  vpd_swap_ctrl swap_i (
    .clk(clk), .rst_n(rst_n_s), .vblank_start(vblank_start),
    .frame_done(host_frame_done), .irq_ack(irq_ack),
    .front_sel(front_sel), .back_full(back_full), .swap(swap), .irq(irq)
  );

  logic [DW-1:0] bank_rdata [NUM_BANKS];
  logic          bank_we    [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_we[b] = host_we && !back_full && (front_sel != b[0]);
    vpd_frame_bank #(.DEPTH(DEPTH), .DW(DW)) bank_i (
      .clk(clk), .we(bank_we[b]), .waddr(host_addr), .wdata(host_data),
      .raddr(rd_addr), .rdata(bank_rdata[b])
    );
  end

  // Align raster control with the one-clock memory read.
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ctl_q <= '{hs_n: 1'b1, vs_n: 1'b1, act: 1'b0};
    end else begin
      ctl_q <= ctl;
    end
  end

  logic [DW-1:0] pix;
  always_comb begin
    pix = ctl_q.act ? bank_rdata[front_sel] : '0;
  end

  assign vga_hsync_n = ctl_q.hs_n;
  assign vga_vsync_n = ctl_q.vs_n;
  assign vga_red     = pix[3*COLOR_W-1:2*COLOR_W];
  assign vga_green   = pix[2*COLOR_W-1:COLOR_W];
  assign vga_blue    = pix[COLOR_W-1:0];
endmodule

// File: rtl/vpd_checker.sv
module vpd_checker #(
  parameter int HA = 640,
  parameter int VA = 480,
  parameter int HW = 10,
  parameter int VW = 10,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n_s,
  input logic [HW-1:0] h_cnt,
  input logic [VW-1:0] v_cnt,
  input logic          vblank_start,
  input logic          front_sel,
  input logic          back_full,
  input logic          irq,
  input logic          irq_ack,
  input logic          vga_vsync_n,
  input logic [CW-1:0] vga_red,
  input logic [CW-1:0] vga_green,
  input logic [CW-1:0] vga_blue
);
  // R4: output one clock behind the raster position stays black in blanking
  a_r4_black_in_blank: assert property (@(posedge clk) disable iff (!rst_n_s)
    ($past(h_cnt) >= HW'(HA) || $past(v_cnt) >= VW'(VA)) |->
      (vga_red == '0 && vga_green == '0 && vga_blue == '0));

  // R3: vertical sync only appears during vertical blanking
  a_r3_vsync_in_vblank: assert property (@(posedge clk) disable iff (!rst_n_s)
    !vga_vsync_n |-> ($past(v_cnt) >= VW'(VA)));

  // R7: role change needs a completed back buffer at blanking start
  a_r7_swap_gated: assert property (@(posedge clk) disable iff (!rst_n_s)
    (front_sel != $past(front_sel)) |-> ($past(back_full) && $past(vblank_start)));

  // R9: the completed mark is kept until a swap consumes it
  a_r9_full_kept: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(back_full) |-> $past(vblank_start));

  // R8: interrupt stays until acknowledged
  a_r8_irq_hold: assert property (@(posedge clk) disable iff (!rst_n_s)
    (irq && !irq_ack) |=> irq);

  // R8: interrupt only rises on a swap
  a_r8_irq_rise: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(irq) |-> ($past(vblank_start) && $past(back_full)));
endmodule

bind vga_pingpong_display vpd_checker #(
  .HA(H_ACTIVE), .VA(V_ACTIVE), .HW(HW), .VW(VW), .CW(COLOR_W)
) chk_i (
  .clk(clk), .rst_n_s(rst_n_s), .h_cnt(h_cnt), .v_cnt(v_cnt),
  .vblank_start(vblank_start), .front_sel(front_sel), .back_full(back_full),
  .irq(irq), .irq_ack(irq_ack), .vga_vsync_n(vga_vsync_n),
  .vga_red(vga_red), .vga_green(vga_green), .vga_blue(vga_blue)
);

// File: tb/vga_pingpong_display_tb.sv
module vga_pingpong_display_tb_top;
  localparam int CW = 8;
  localparam int SW = 4, SH = 3, SC = 2;
  localparam int HA = 8, HF = 2, HS = 3, HB = 3;
  localparam int VA = 6, VF = 1, VS = 2, VB = 2;
  localparam int HT = HA + HF + HS + HB;
  localparam int VT = VA + VF + VS + VB;
  localparam int NPIX = SW * SH;
  localparam int AW = $clog2(NPIX);

  logic clk, rst_n, host_we, host_frame_done, irq_ack, irq;
  logic [AW-1:0] host_addr;
  logic [3*CW-1:0] host_data;
  logic hs_n, vs_n;
  logic [CW-1:0] red, green, blue;

  int n_checks = 0, n_fails = 0;
  logic [3*CW-1:0] img [NPIX];

  vga_pingpong_display #(
    .COLOR_W(CW), .SRC_W(SW), .SRC_H(SH), .SCALE(SC),
    .H_ACTIVE(HA), .H_FRONT(HF), .H_SYNC(HS), .H_BACK(HB),
    .V_ACTIVE(VA), .V_FRONT(VF), .V_SYNC(VS), .V_BACK(VB)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_data(host_data), .host_frame_done(host_frame_done),
    .irq_ack(irq_ack), .irq(irq), .vga_hsync_n(hs_n), .vga_vsync_n(vs_n),
    .vga_red(red), .vga_green(green), .vga_blue(blue)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3*CW-1:0] pix_of(input int seed, input int i);
    return {8'(seed * 37 + i * 11 + 1), 8'(i * 29 + seed + 3), 8'(250 - i * 7 - seed)};
  endfunction

  task automatic make_image(input int seed);
    for (int i = 0; i < NPIX; i++) img[i] = pix_of(seed, i);
  endtask

  task automatic write_frame(input int seed);
    for (int i = 0; i < NPIX; i++) begin
      host_we   = 1'b1;
      host_addr = AW'(i);
      host_data = pix_of(seed, i);
      @(negedge clk);
    end
    host_we = 1'b0;
  endtask

  task automatic pulse_done();
    host_frame_done = 1'b1;
    @(negedge clk);
    host_frame_done = 1'b0;
  endtask

  // Returns at the negedge where the output shows pixel (0,0) of a frame.
  task automatic wait_frame_start();
    logic prev;
    prev = vs_n;
    @(negedge clk);
    while (!(prev && !vs_n)) begin
      prev = vs_n;
      @(negedge clk);
    end
    repeat ((VT - VA - VF) * HT) @(negedge clk);
  endtask

  task automatic wait_irq(input string req);
    int n = 0;
    while (!irq && n < 3 * HT * VT) begin
      @(negedge clk);
      n++;
    end
    check(irq, req, "irq after done strobe", irq, 1);
  endtask

  task automatic ack_irq();
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    check(!irq, "R8", "irq after ack", irq, 0);
  endtask

  // Scan one whole raster from (0,0) and compare to img.
  task automatic scan_frame(input string req);
    int bad_pix = 0, bad_blank = 0, bad_hs = 0, bad_vs = 0;
    logic [3*CW-1:0] a_pix = '0, e_pix = '0, got;
    for (int p = 0; p < HT * VT; p++) begin
      int h = p % HT, v = p / HT;
      bit ehs = !(h >= HA + HF && h < HA + HF + HS);
      bit evs = !(v >= VA + VF && v < VA + VF + VS);
      got = {red, green, blue};
      if (h < HA && v < VA) begin
        if (got !== img[(v / SC) * SW + h / SC]) begin
          if (bad_pix == 0) begin a_pix = got; e_pix = img[(v / SC) * SW + h / SC]; end
          bad_pix++;
        end
      end else if (got !== '0) bad_blank++;
      if (hs_n !== ehs) bad_hs++;
      if (vs_n !== evs) bad_vs++;
      @(negedge clk);
    end
    check(bad_pix == 0, req, "visible pixels (R5 first mismatch)", a_pix, e_pix);
    check(bad_blank == 0, "R4", "non-black samples in blanking", bad_blank, 0);
    check(bad_hs == 0, "R2", "hsync mismatches", bad_hs, 0);
    check(bad_vs == 0, "R3", "vsync mismatches", bad_vs, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; host_we = 1'b0; host_addr = '0; host_data = '0;
    host_frame_done = 1'b0; irq_ack = 1'b0;
    repeat (3) @(negedge clk);
    check(hs_n === 1'b1, "R1", "hsync in reset", hs_n, 1);
    check(vs_n === 1'b1, "R1", "vsync in reset", vs_n, 1);
    check({red, green, blue} === '0, "R1", "colour in reset", {red, green, blue}, 0);
    check(irq === 1'b0, "R1", "irq in reset", irq, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_first_frame();
    write_frame(1);
    pulse_done();
    wait_irq("R8");
    repeat (5) @(negedge clk);
    check(irq, "R8", "irq held without ack", irq, 1);
    ack_irq();
    make_image(1);
    wait_frame_start();
    scan_frame("R5");
  endtask

  task automatic t_repeat();
    wait_frame_start();
    scan_frame("R7");
    check(!irq, "R7", "no irq without done strobe", irq, 0);
  endtask

  task automatic t_back_write();
    wait_frame_start();
    write_frame(2);
    wait_frame_start();
    scan_frame("R6");
    pulse_done();
    wait_irq("R10");
    ack_irq();
    make_image(2);
    wait_frame_start();
    scan_frame("R10");
  endtask

  task automatic t_ignore_full();
    wait_frame_start();
    write_frame(3);
    pulse_done();
    write_frame(4);
    wait_irq("R9");
    ack_irq();
    make_image(3);
    wait_frame_start();
    scan_frame("R9");
  endtask

  bit done = 0;
  initial begin
    t_reset();
    t_first_frame();
    t_repeat();
    t_back_write();
    t_ignore_full();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  end
endmodule